// File: doc/BRIEF.md
# Selectable Test-Pattern Source and PRBS Checker

This block sits in a streaming sample path. On the transmit side it takes sample words from a memory-fed FIFO interface and hands them to a converter core. On the receive side it passes converter samples back towards memory. A control word chooses whether transmit samples go through untouched or are replaced by an internal source. The internal source is one of three: a sine tone at one eighth of the sample rate, a 15-bit pseudo-random sequence, or a fixed alternating word pattern. The replacement can apply to every channel or to one chosen channel.

On the receive side, a self-synchronising pseudo-random sequence checker watches one channel. It raises a sticky error flag and an out-of-sync flag. A status word carries both flags next to a hard-wired logic identifier. The checker only gives useful results when the transmit output is looped back digitally to the receive input.

Each bus packs `NCH` channels of `DW` bits. Channel c occupies bits `[c*DW +: DW]`. The default is two channels of 16 bits.

Top module: `tpat_src_chk`

## Requirements
- R1: After reset, the source is pass-through, the channel field is 0, the error flag is 0 and the out-of-sync flag is 1, so `status` reads 0x0000_01A1.
- R2: `status[7:0]` always reads 0xA1 and `status[31:10]` always reads zero. Bit 9 is the error flag and bit 8 is the out-of-sync flag.
- R3: The source field is `cfg_wdata[7:4]`. Value 0, and any value from 4 to 15, is pass-through: `tx_out_data` equals `tx_in_data` in the same cycle. The receive outputs always equal the receive inputs in the same cycle, and each valid output equals its valid input.
- R4: Source 1 is the sine tone. With k the number of transmit valid samples accepted since reset (counted in every mode), the word is entry k mod 8 of the table 0x0000, 0x5A82, 0x7FFF, 0x5A82, 0x0000, 0xA57E, 0x8001, 0xA57E.
- R5: Source 2 is the PRBS. The bit stream obeys s[n] = s[n-14] xor s[n-15] and is seeded with fifteen ones. Each transmit valid sample consumes 16 new bits, with the first bit in the word's MSB. The generator advances on every transmit valid sample, in every mode.
- R6: Source 3 outputs 0x5555 when k is even and 0xAAAA when k is odd.
- R7: The channel field is `cfg_wdata[3:0]`. Value 0 applies the source to all channels. A value v from 1 to NCH applies it only to channel v-1, and the other channels pass through. A value above NCH leaves every channel passing through.
- R8: The checker acts only on receive valid samples while the source is 2. It watches channel v-1 when the channel field v is between 1 and NCH, and channel 0 otherwise. It predicts each word from the previous word it watched, using the R5 rule on that word's 15 least significant bits. The first watched word after reset is only stored.
- R9: While out of sync, 16 consecutive matches clear the out-of-sync flag. While in sync, 16 consecutive mismatches set it again. A match resets the mismatch count, and a mismatch resets the match count.
- R10: Any mismatch while in sync sets the error flag. The flag holds until a control write or a reset. If both happen in the same cycle, the write's clear wins.
- R11: A control write (`cfg_wr` high) takes effect from the next clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word; [7:4] source, [3:0] channel, rest unused |
| status | output | 32 | {22'b0, error, out-of-sync, 8'hA1} |
| tx_in_valid | input | 1 | Transmit sample strobe from the memory side |
| tx_in_data | input | NCH*DW | Transmit samples from the memory side |
| tx_out_valid | output | 1 | Transmit sample strobe to the converter |
| tx_out_data | output | NCH*DW | Transmit samples to the converter |
| rx_in_valid | input | 1 | Receive sample strobe from the converter |
| rx_in_data | input | NCH*DW | Receive samples from the converter |
| rx_out_valid | output | 1 | Receive sample strobe to the memory side |
| rx_out_data | output | NCH*DW | Receive samples to the memory side |

## Verification
The bench inserts idle gaps in the valid strobe while the tone and alternation modes run. A design that advanced its generators on every clock would then show the wrong table entry or the wrong polarity. It selects one channel, and then a channel number above the channel count. A wrong decode would overwrite a channel that should pass through, or would treat the out-of-range value as "all channels". It injects a single corrupted word after lock. Because the checker is self-synchronising, that word gives two mismatches, and a checker that lost sync or failed to hold the sticky error flag would be caught. It also feeds inverted data for longer than the loss window, and rewrites the control word while an error is latched. A wrong threshold or a wrong clear priority would shift the out-of-sync or error edges by a cycle.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

   localparam logic [7:0] LOGIC_ID = 8'hA1;

   localparam logic [3:0] SRC_PASS = 4'd0;
   localparam logic [3:0] SRC_SINE = 4'd1;
   localparam logic [3:0] SRC_PRBS = 4'd2;
   localparam logic [3:0] SRC_ALT  = 4'd3;

   localparam int PN_LEN = 15;
   localparam int MAX_W  = 64;

   // Quarter-wave-symmetric eighth-rate tone, Q15 amplitude.
   function automatic logic [15:0] sine_q15(input logic [2:0] idx);
      logic [15:0] v;
      case (idx)
         3'd0, 3'd4: v = 16'h0000;
         3'd1, 3'd3: v = 16'h5A82;
         3'd2:       v = 16'h7FFF;
         3'd5, 3'd7: v = 16'hA57E;
         default:    v = 16'h8001;
      endcase
      return v;
   endfunction

   // Runs the 15-bit recurrence nbits times from a state whose bit 14 is
   // the oldest bit; the newest bit lands in bit 0 of the result.
   function automatic logic [MAX_W-1:0] pn_word(input logic [PN_LEN-1:0] st,
                                                input int nbits);
      logic [PN_LEN-1:0] s;
      logic              nb;
      logic [MAX_W-1:0]  w;
      s = st;
      w = '0;
      for (int i = 0; i < MAX_W; i++) begin
         if (i < nbits) begin
            nb = s[PN_LEN-1] ^ s[PN_LEN-2];
            s  = {s[PN_LEN-2:0], nb};
            w  = {w[MAX_W-2:0], nb};
         end
      end
      return w;
   endfunction

endpackage

// File: rtl/tpat_ctrl.sv
module tpat_ctrl (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic [31:0] cfg_wdata,
   output logic [3:0]  cfg_mode,
   output logic [3:0]  cfg_chan
);

   logic cfg_unused;
   assign cfg_unused = ^cfg_wdata[31:8];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_mode <= 4'd0;
         cfg_chan <= 4'd0;
      end else if (cfg_wr) begin
         cfg_mode <= cfg_wdata[7:4];
         cfg_chan <= cfg_wdata[3:0];
      end
   end

endmodule

// File: rtl/tpat_gen.sv
module tpat_gen
   import tpat_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [DW-1:0] sine_w,
   output logic [DW-1:0] prbs_w,
   output logic [DW-1:0] alt_w
);

   localparam int PH_W = 3;

   logic [PN_LEN-1:0] pn_st;
   logic [PH_W-1:0]   phase;
   logic              alt_odd;
   logic [MAX_W-1:0]  pn_full;
   logic [15:0]       tone;
   logic              pn_unused;

   assign pn_full   = pn_word(pn_st, DW);
   assign prbs_w    = pn_full[DW-1:0];
   assign pn_unused = ^pn_full[MAX_W-1:DW];
   assign tone      = sine_q15(phase);
   assign alt_w     = alt_odd ? {(DW/2){2'b10}} : {(DW/2){2'b01}};

   generate
      if (DW == 16) begin : g_tone_exact
         assign sine_w = tone;
      end else begin : g_tone_wide
         assign sine_w = {tone, {(DW-16){1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pn_st   <= '1;
         phase   <= '0;
         alt_odd <= 1'b0;
      end else if (adv) begin
         pn_st   <= prbs_w[PN_LEN-1:0];
         phase   <= phase + 1'b1;
         alt_odd <= ~alt_odd;
      end
   end

endmodule

// File: rtl/tpat_lane.sv
module tpat_lane
   import tpat_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [3:0]    mode,
   input  logic          hit,
   input  logic [DW-1:0] din,
   input  logic [DW-1:0] sine_w,
   input  logic [DW-1:0] prbs_w,
   input  logic [DW-1:0] alt_w,
   output logic [DW-1:0] dout
);

   always_comb begin
      dout = din;
      if (hit) begin
         case (mode)
            SRC_SINE: dout = sine_w;
            SRC_PRBS: dout = prbs_w;
            SRC_ALT:  dout = alt_w;
            default:  dout = din;
         endcase
      end
   end

endmodule

// File: rtl/tpat_chk.sv
module tpat_chk
   import tpat_pkg::*;
#(
   parameter int DW       = 16,
   parameter int SYNC_CNT = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          clr,
   input  logic [DW-1:0] word,
   output logic          oos,
   output logic          err
);

   localparam int CW = $clog2(SYNC_CNT + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(SYNC_CNT - 1);

   logic [DW-1:0]    prev;
   logic             have;
   logic [CW-1:0]    cnt;
   logic [MAX_W-1:0] pred_full;
   logic             match;
   logic             pred_unused;

   assign pred_full   = pn_word(prev[PN_LEN-1:0], DW);
   assign match       = (word == pred_full[DW-1:0]);
   assign pred_unused = ^pred_full[MAX_W-1:DW];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev <= '0;
         have <= 1'b0;
         cnt  <= '0;
         oos  <= 1'b1;
      end else if (en) begin
         prev <= word;
         have <= 1'b1;
         if (have) begin
            if (oos == match) begin
               if (cnt == CNT_LAST) begin
                  oos <= ~oos;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end else begin
               cnt <= '0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                           err <= 1'b0;
      else if (clr)                         err <= 1'b0;
      else if (en && have && !oos && !match) err <= 1'b1;
   end

endmodule

// File: rtl/tpat_src_chk.sv
module tpat_src_chk
   import tpat_pkg::*;
#(
   parameter int NCH      = 2,
   parameter int DW       = 16,
   parameter int SYNC_CNT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       status,
   input  logic              tx_in_valid,
   input  logic [NCH*DW-1:0] tx_in_data,
   output logic              tx_out_valid,
   output logic [NCH*DW-1:0] tx_out_data,
   input  logic              rx_in_valid,
   input  logic [NCH*DW-1:0] rx_in_data,
   output logic              rx_out_valid,
   output logic [NCH*DW-1:0] rx_out_data
);

   if (NCH < 1 || NCH > 15) begin : g_bad_nch
      $error("NCH must lie in 1..15");
   end
   if (DW < 16 || DW >= MAX_W || (DW % 2) != 0) begin : g_bad_dw
      $error("DW must be even and in 16..62");
   end
   if (SYNC_CNT < 2) begin : g_bad_sync
      $error("SYNC_CNT must be at least 2");
   end

   logic [3:0]    cfg_mode;
   logic [3:0]    cfg_chan;
   logic [DW-1:0] sine_w, prbs_w, alt_w;
   logic [DW-1:0] mon_word;
   logic          chk_en, chk_oos, chk_err;

   tpat_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_wdata (cfg_wdata),
      .cfg_mode  (cfg_mode),
      .cfg_chan  (cfg_chan)
   );

   tpat_gen #(.DW(DW)) u_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (tx_in_valid),
      .sine_w (sine_w),
      .prbs_w (prbs_w),
      .alt_w  (alt_w)
   );

   for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
      logic hit;
      assign hit = (cfg_chan == 4'd0) || (cfg_chan == 4'(ch + 1));
      tpat_lane #(.DW(DW)) u_lane (
         .mode   (cfg_mode),
         .hit    (hit),
         .din    (tx_in_data[ch*DW +: DW]),
         .sine_w (sine_w),
         .prbs_w (prbs_w),
         .alt_w  (alt_w),
         .dout   (tx_out_data[ch*DW +: DW])
      );
   end

   always_comb begin
      mon_word = rx_in_data[DW-1:0];
      for (int c = 1; c < NCH; c++) begin
         if (cfg_chan == 4'(c + 1)) mon_word = rx_in_data[c*DW +: DW];
      end
   end

   assign chk_en = rx_in_valid && (cfg_mode == SRC_PRBS);

   tpat_chk #(.DW(DW), .SYNC_CNT(SYNC_CNT)) u_chk (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (chk_en),
      .clr   (cfg_wr),
      .word  (mon_word),
      .oos   (chk_oos),
      .err   (chk_err)
   );

   assign tx_out_valid = tx_in_valid;
   assign rx_out_valid = rx_in_valid;
   assign rx_out_data  = rx_in_data;
   assign status       = {22'd0, chk_err, chk_oos, LOGIC_ID};

endmodule

// File: rtl/tpat_src_chk_sva.sv
module tpat_src_chk_sva
   import tpat_pkg::*;
#(
   parameter int NCH = 2,
   parameter int DW  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [31:0]       status,
   input logic              tx_in_valid,
   input logic [NCH*DW-1:0] tx_in_data,
   input logic              tx_out_valid,
   input logic [NCH*DW-1:0] tx_out_data,
   input logic              rx_in_valid,
   input logic [NCH*DW-1:0] rx_in_data,
   input logic              rx_out_valid,
   input logic [NCH*DW-1:0] rx_out_data,
   input logic [3:0]        cfg_mode,
   input logic [3:0]        cfg_chan
);

   localparam logic [DW-1:0] ALT_EVEN = {(DW/2){2'b01}};
   localparam logic [DW-1:0] ALT_ODD  = {(DW/2){2'b10}};

   assert_tx_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == SRC_PASS) |-> (tx_out_data == tx_in_data && tx_out_valid == tx_in_valid));

   assert_rx_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_out_data == rx_in_data) && (rx_out_valid == rx_in_valid));

   assert_alt_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == SRC_ALT && cfg_chan == 4'd0) |->
         (tx_out_data[DW-1:0] == ALT_EVEN || tx_out_data[DW-1:0] == ALT_ODD));

   assert_chan_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_chan > 4'(NCH)) |-> (tx_out_data == tx_in_data));

   assert_oos_on_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(status[8]) || $fell(status[8])) |-> $past(rx_in_valid));

   assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (status[9] && !cfg_wr) |=> status[9]);

   assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> !status[9]);

endmodule

bind tpat_src_chk tpat_src_chk_sva #(.NCH(NCH), .DW(DW)) u_sva (.*);

// File: tb/tpat_src_chk_tb.sv
`timescale 1ns/1ps
module tpat_src_chk_tb;

   localparam int NCH = 2;
   localparam int DW  = 16;
   localparam int BW  = NCH * DW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_wr;
   logic [31:0]   cfg_wdata;
   logic [31:0]   status;
   logic          tx_in_valid, tx_out_valid, rx_in_valid, rx_out_valid;
   logic [BW-1:0] tx_in_data, tx_out_data, rx_in_data, rx_out_data;

   always #2.5 clk = ~clk;

   tpat_src_chk #(.NCH(NCH), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .status(status), .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data),
      .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
      .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
      .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   // reference model state
   int          m_mode = 0, m_chan = 0, m_k = 0;
   bit          pnq[$];
   logic [15:0] m_prev = '0;
   bit          m_have = 0, m_oos = 1, m_err = 0;
   int          m_cnt  = 0;

   task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] tone(int i);
      case (i % 8)
         0, 4:    return 16'h0000;
         1, 3:    return 16'h5A82;
         2:       return 16'h7FFF;
         5, 7:    return 16'hA57E;
         default: return 16'h8001;
      endcase
   endfunction

   function automatic logic [15:0] run_bits(ref bit q[$]);
      logic [15:0] w = '0;
      for (int i = 0; i < 16; i++) begin
         bit nb = q[0] ^ q[1];
         void'(q.pop_front());
         q.push_back(nb);
         w = {w[14:0], nb};
      end
      return w;
   endfunction

   function automatic logic [15:0] pn_peek();
      bit q[$] = pnq;
      return run_bits(q);
   endfunction

   function automatic logic [15:0] pn_predict(logic [15:0] p);
      bit q[$];
      for (int b = 14; b >= 0; b--) q.push_back(p[b]);
      return run_bits(q);
   endfunction

   function automatic logic [BW-1:0] exp_tx(logic [BW-1:0] td);
      logic [BW-1:0] r = td;
      logic [15:0]   g;
      bit            on = (m_mode >= 1 && m_mode <= 3);
      case (m_mode)
         1:       g = tone(m_k);
         2:       g = pn_peek();
         3:       g = (m_k % 2) ? 16'hAAAA : 16'h5555;
         default: g = '0;
      endcase
      for (int ch = 0; ch < NCH; ch++)
         if (on && (m_chan == 0 || m_chan == ch + 1)) r[ch*DW +: DW] = g;
      return r;
   endfunction

   task automatic step(string tag, bit cw, logic [31:0] cd, bit tv, bit rv,
                       bit loopb, logic [BW-1:0] rpat);
      logic [BW-1:0] td, et, rd;
      logic [31:0]   es;
      logic [15:0]   w;
      int            mon;
      @(negedge clk);
      td = BW'($urandom());
      et = exp_tx(td);
      rd = loopb ? (et ^ rpat) : rpat;
      cfg_wr = cw; cfg_wdata = cd;
      tx_in_valid = tv; tx_in_data = td;
      rx_in_valid = rv; rx_in_data = rd;
      #1;
      es = {22'd0, m_err, m_oos, 8'hA1};
      check(tx_out_data === et, tag, "tx_out_data", 64'(tx_out_data), 64'(et));
      check(tx_out_valid === tv, "R3", "tx_out_valid", 64'(tx_out_valid), 64'(tv));
      check(rx_out_data === rd && rx_out_valid === rv, "R3", "rx_out",
            64'({rx_out_valid, rx_out_data}), 64'({rv, rd}));
      check(status === es, "R9/R10 status", "status", 64'(status), 64'(es));
      @(posedge clk);
      // checker model (R8, R9, R10)
      mon = (m_chan >= 1 && m_chan <= NCH) ? m_chan - 1 : 0;
      w   = rd[mon*DW +: DW];
      if (rv && m_mode == 2) begin
         if (m_have) begin
            bit mt = (w == pn_predict(m_prev));
            if (!m_oos && !mt) m_err = 1;
            if (m_oos == mt) begin
               m_cnt++;
               if (m_cnt == 16) begin m_oos = !m_oos; m_cnt = 0; end
            end else m_cnt = 0;
         end
         m_prev = w;
         m_have = 1;
      end
      if (cw) m_err = 0;
      if (tv) begin
         void'(run_bits(pnq));
         m_k++;
      end
      if (cw) begin
         m_mode = int'(cd[7:4]);
         m_chan = int'(cd[3:0]);
      end
   endtask

   initial begin
      for (int i = 0; i < 15; i++) pnq.push_back(1'b1);
      rst_n = 0; cfg_wr = 0; cfg_wdata = '0;
      tx_in_valid = 0; tx_in_data = '0; rx_in_valid = 0; rx_in_data = '0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      check(status === 32'h0000_01A1, "R1", "status after reset", 64'(status), 64'h1A1);
      check(tx_out_data === tx_in_data, "R1", "reset pass-through", 64'(tx_out_data), 64'(tx_in_data));
      check(status[7:0] === 8'hA1 && status[31:10] === '0, "R2", "id field", 64'(status), 64'h1A1);

      for (int i = 0; i < 6; i++) step("R3", 0, 0, i % 2, 1, 0, BW'($urandom()));
      step("R11", 1, 32'hFFFF_FF10, 0, 0, 0, 0);
      for (int i = 0; i < 14; i++) step("R4", 0, 0, (i % 3) != 1, 0, 0, 0);
      step("R11", 1, 32'h32, 1, 0, 0, 0);
      for (int i = 0; i < 8; i++) step("R7", 0, 0, i != 3, 0, 0, 0);
      step("R11", 1, 32'h30, 0, 0, 0, 0);
      for (int i = 0; i < 7; i++) step("R6", 0, 0, (i % 3) == 0, 0, 0, 0);
      step("R11", 1, 32'h20, 1, 1, 1, 0);
      for (int i = 0; i < 20; i++) step("R5", 0, 0, 1, 1, 1, 0);
      step("R10", 0, 0, 1, 1, 1, 32'h0000_0001);
      for (int i = 0; i < 4; i++) step("R10", 0, 0, 1, 1, 1, 0);
      step("R10", 1, 32'h20, 1, 1, 1, 0);
      for (int i = 0; i < 3; i++) step("R10", 0, 0, 1, 1, 1, 0);
      for (int i = 0; i < 20; i++) step("R9", 0, 0, 1, 1, 1, 32'h0000_FFFF);
      step("R11", 1, 32'h24, 1, 1, 0, 0);
      for (int i = 0; i < 5; i++) step("R7", 0, 0, 1, 1, 0, BW'($urandom()));
      step("R11", 1, 32'h50, 1, 0, 0, 0);
      for (int i = 0; i < 5; i++) step("R3", 0, 0, 1, 0, 0, 0);
      step("R11", 1, 32'h21, 1, 1, 1, 0);
      for (int i = 0; i < 20; i++) step("R8", 0, 0, 1, 1, 1, 32'hFFFF_0000);
      step("R8", 0, 0, 0, 0, 0, 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule